// File: doc/BRIEF.md
# Palette Colour Converter

This block turns a stream of 32-bit palette words into 8-bit red, green and blue components plus a transparency flag. It writes each converted entry into an internal palette RAM, and a pixel lookup stage reads that RAM through a separate read port. A load starts when a start pulse arrives. The pulse captures three selections: the entry format, the monochrome override and the pixel depth. The pixel depth sets how many entries the load converts.

Palette words arrive on a valid/ready stream, and the block accepts one word per clock cycle. The block raises `in_ready` only while a load is open. The producer must hold `in_data` steady while `in_valid` is high, until a cycle in which `in_ready` is also high. A word is taken on every clock edge where both signals are high. The producer may leave gaps by dropping `in_valid`. After the last entry of the load, the block drops `in_ready`. It never applies back-pressure in the middle of a load.

The `reconv` output compares the format selector currently on the pins with the format of the last load that completed. Control logic uses it to decide that the palette has to be loaded again.

Top module: `pal_convert_top`

## Requirements
- R1: After reset, `in_ready` is 0, `done` is 0 and `reconv` is 1.
- R2: When the block is idle, a one-cycle `start` captures `fmt_sel`, `mono` and `depth_sel`. For depth codes 0, 1 and 2, `in_ready` is 1 in the cycle after `start`. A `start` that arrives while a load is open is ignored, and the open load keeps its captured settings.
- R3: Each cycle with `in_valid` and `in_ready` both high writes one converted entry. The entries go to consecutive palette addresses, starting at 0. Gaps in `in_valid` are allowed. `in_valid` while `in_ready` is low writes nothing.
- R4: The load length depends on the depth code: 4 entries for code 0 (2 bpp), 16 for code 1 (4 bpp) and 256 for code 2 (8 bpp). `done` is a one-cycle pulse in the cycle after the last handshake, and `in_ready` is 0 in that cycle.
- R5: Depth code 3 (a deeper pixel mode that has no palette) writes no entry. It pulses `done` in the cycle after `start` and leaves `in_ready` at 0.
- R6: Format code 0: red = {word[15:11],000}, green = {word[10:5],00}, blue = {word[4:0],000}. Transparency is 0.
- R7: Format code 1 uses the same colour layout as code 0, with transparency = word[24].
- R8: Format code 2: red = {word[23:19],000}, green = {word[15:10],00}, blue = {word[7:3],000}. Transparency = word[24].
- R9: Format code 3: red = word[23:16], green = word[15:8], blue = word[7:0]. Transparency = word[24].
- R10: When `mono` is 1, red, green and blue all equal word[7:0] in every format. Transparency still follows the format rule.
- R11: `reconv` is 1 when no load with a palette has completed since reset. It is also 1 when `fmt_sel` differs from the format of the most recent completed load. Otherwise it is 0. A depth-3 start does not change this reference.
- R12: The read port returns the entry at `rd_addr` on `rd_red`, `rd_grn`, `rd_blu` and `rd_tr`, one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a palette load |
| depth_sel | input | 2 | Pixel depth code (0: 2 bpp, 1: 4 bpp, 2: 8 bpp, 3: no palette) |
| fmt_sel | input | 2 | Entry format code 0..3 |
| mono | input | 1 | Monochrome override |
| in_valid | input | 1 | Palette word valid |
| in_ready | output | 1 | Block accepts a palette word |
| in_data | input | 32 | Palette word |
| done | output | 1 | Load-complete pulse |
| reconv | output | 1 | Format differs from the last completed load |
| rd_addr | input | 8 | Palette read address |
| rd_red | output | 8 | Red component of the addressed entry |
| rd_grn | output | 8 | Green component of the addressed entry |
| rd_blu | output | 8 | Blue component of the addressed entry |
| rd_tr | output | 1 | Transparency flag of the addressed entry |

## Verification
Every format code is loaded both with and without the monochrome override. Each load uses pseudo-random words with bit 24 varying, so a swapped field, a wrong shift or a misplaced transparency source shows up as a wrong component on readback. A 4 bpp load has gaps in `in_valid` and a stray `start` in the middle. It separates the correct behaviour, which holds the address and ignores the stray pulse, from a design that advances on idle cycles or restarts on the pulse. A full 256-entry load checks the longest count and the end-of-load boundary. Words offered while idle and a depth-3 start must both leave the stored entries untouched and leave the `reconv` reference unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int WORD_W = 32;
  localparam int CH_W   = 8;

  typedef enum logic [1:0] {
    FMT_565  = 2'd0,
    FMT_565T = 2'd1,
    FMT_666T = 2'd2,
    FMT_888T = 2'd3
  } pal_fmt_e;

  typedef enum logic [1:0] {
    DEP_2    = 2'd0,
    DEP_4    = 2'd1,
    DEP_8    = 2'd2,
    DEP_NONE = 2'd3
  } pal_dep_e;

  typedef struct packed {
    logic            tr;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } pal_ent_t;

  localparam int ENT_W = $bits(pal_ent_t);
endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import pal_pkg::*;
(
  input  pal_fmt_e          fmt,
  input  logic              mono,
  input  logic [WORD_W-1:0] word,
  output pal_ent_t          ent
);
  localparam int TR_BIT = 24;

  logic [CH_W-1:0] r565, g565, b565;
  logic [CH_W-1:0] r666, g666, b666;
  logic [CH_W-1:0] r888, g888, b888;

  assign r565 = {word[15:11], 3'b000};
  assign g565 = {word[10:5],  2'b00};
  assign b565 = {word[4:0],   3'b000};

  assign r666 = {word[23:19], 3'b000};
  assign g666 = {word[15:10], 2'b00};
  assign b666 = {word[7:3],   3'b000};

  assign r888 = word[23:16];
  assign g888 = word[15:8];
  assign b888 = word[7:0];

  always_comb begin
    ent.tr = (fmt == FMT_565) ? 1'b0 : word[TR_BIT];
    unique case (fmt)
      FMT_565, FMT_565T: begin ent.r = r565; ent.g = g565; ent.b = b565; end
      FMT_666T:          begin ent.r = r666; ent.g = g666; ent.b = b666; end
      default:           begin ent.r = r888; ent.g = g888; ent.b = b888; end
    endcase
    if (mono) begin
      ent.r = word[CH_W-1:0];
      ent.g = word[CH_W-1:0];
      ent.b = word[CH_W-1:0];
    end
  end
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  pal_dep_e         depth_in,
  input  pal_fmt_e         fmt_in,
  input  logic             mono_in,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [IDX_W-1:0] last_q,
  output pal_fmt_e         fmt_q,
  output logic             mono_q,
  output logic             done,
  output pal_fmt_e         used_fmt,
  output logic             have_used
);
  localparam logic [IDX_W-1:0] LAST_2 = IDX_W'((1 << 2) - 1);
  localparam logic [IDX_W-1:0] LAST_4 = IDX_W'((1 << 4) - 1);
  localparam logic [IDX_W-1:0] LAST_8 = IDX_W'((1 << 8) - 1);

  logic             busy;
  logic [IDX_W-1:0] cnt;

  function automatic logic [IDX_W-1:0] last_of(input pal_dep_e d);
    case (d)
      DEP_2:   return LAST_2;
      DEP_4:   return LAST_4;
      default: return LAST_8;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      last_q    <= '0;
      fmt_q     <= FMT_565;
      mono_q    <= 1'b0;
      done      <= 1'b0;
      used_fmt  <= FMT_565;
      have_used <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        fmt_q  <= fmt_in;
        mono_q <= mono_in;
        if (depth_in == DEP_NONE) begin
          done <= 1'b1;
        end else begin
          busy   <= 1'b1;
          cnt    <= '0;
          last_q <= last_of(depth_in);
        end
      end else if (busy && in_valid) begin
        cnt <= cnt + 1'b1;
        if (cnt == last_q) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          used_fmt  <= fmt_q;
          have_used <= 1'b1;
        end
      end
    end
  end

  assign in_ready = busy;
  assign wr_en    = busy && in_valid;
  assign wr_addr  = cnt;
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int AW = 8,
  parameter int DW = 25
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_convert_top.sv
module pal_convert_top
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       depth_sel,
  input  logic [1:0]       fmt_sel,
  input  logic             mono,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             done,
  output logic             reconv,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_red,
  output logic [7:0]       rd_grn,
  output logic [7:0]       rd_blu,
  output logic             rd_tr
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [IDX_W-1:0] last_q;
  pal_fmt_e         fmt_q;
  logic             mono_q;
  pal_fmt_e         used_fmt;
  logic             have_used;
  pal_ent_t         wr_ent;
  pal_ent_t         rd_ent;

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .depth_in  (pal_dep_e'(depth_sel)),
    .fmt_in    (pal_fmt_e'(fmt_sel)),
    .mono_in   (mono),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .last_q    (last_q),
    .fmt_q     (fmt_q),
    .mono_q    (mono_q),
    .done      (done),
    .used_fmt  (used_fmt),
    .have_used (have_used)
  );

  pal_decode u_dec (
    .fmt  (fmt_q),
    .mono (mono_q),
    .word (in_data),
    .ent  (wr_ent)
  );

  pal_ram #(.AW(IDX_W), .DW(ENT_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_ent),
    .raddr (rd_addr),
    .rdata (rd_ent)
  );

  assign reconv = !have_used || (pal_fmt_e'(fmt_sel) != used_fmt);
  assign rd_red = rd_ent.r;
  assign rd_grn = rd_ent.g;
  assign rd_blu = rd_ent.b;
  assign rd_tr  = rd_ent.tr;
endmodule

// File: rtl/pal_convert_chk.sv
module pal_convert_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_ready,
  input logic             done,
  input logic             wr_en,
  input logic [IDX_W-1:0] cnt,
  input logic [IDX_W-1:0] lim,
  input logic [1:0]       fmt_q,
  input logic             mono_q,
  input logic [24:0]      ent,
  input logic [31:0]      in_data
);
  p_ready_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start));

  p_done_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cnt <= lim));

  p_fmt0_opaque_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt_q == 2'd0) |-> !ent[24]);

  p_fmt3_blue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt_q == 2'd3 && !mono_q) |-> (ent[7:0] == in_data[7:0]));

  p_mono_grey_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mono_q) |-> (ent[23:16] == in_data[7:0] && ent[15:8] == in_data[7:0]
                           && ent[7:0] == in_data[7:0]));
endmodule

bind pal_convert_top pal_convert_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_ready (in_ready),
  .done     (done),
  .wr_en    (wr_en),
  .cnt      (wr_addr),
  .lim      (last_q),
  .fmt_q    (fmt_q),
  .mono_q   (mono_q),
  .ent      (wr_ent),
  .in_data  (in_data)
);

// File: tb/sim_pal_convert_top.sv
module sim_pal_convert_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  depth_sel = 2'd0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        mono = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = 32'h0;
  logic        done;
  logic        reconv;
  logic [7:0]  rd_addr = 8'h0;
  logic [7:0]  rd_red, rd_grn, rd_blu;
  logic        rd_tr;

  int total = 0;
  int bad = 0;
  int wptr = 0;
  int cur_f = 0;
  bit cur_m = 1'b0;
  logic [24:0] exp_mem [256];

  always #10 clk = ~clk;

  pal_convert_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .depth_sel(depth_sel),
    .fmt_sel(fmt_sel), .mono(mono), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done(done), .reconv(reconv), .rd_addr(rd_addr),
    .rd_red(rd_red), .rd_grn(rd_grn), .rd_blu(rd_blu), .rd_tr(rd_tr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] expc(input int f, input bit m, input logic [31:0] d);
    int r, g, b, t;
    if (f <= 1) begin
      r = ((d >> 11) & 31) * 8; g = ((d >> 5) & 63) * 4; b = (d & 31) * 8;
    end else if (f == 2) begin
      r = ((d >> 19) & 31) * 8; g = ((d >> 10) & 63) * 4; b = ((d >> 3) & 31) * 8;
    end else begin
      r = (d >> 16) & 255; g = (d >> 8) & 255; b = d & 255;
    end
    if (m) begin r = d & 255; g = r; b = r; end
    t = (f == 0) ? 0 : ((d >> 24) & 1);
    return {t[0], r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic string ftag(input int f, input bit m);
    if (m) return "R10";
    case (f)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] pat(input int i, input int seed);
    return (i + seed * 97) * 32'h9E3779B1 ^ (32'(seed) << 20);
  endfunction

  task automatic begin_load(input int f, input bit m, input int dep);
    fmt_sel = f[1:0]; mono = m; depth_sel = dep[1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dep != 3) begin cur_f = f; cur_m = m; wptr = 0; end
  endtask

  task automatic push(input logic [31:0] d);
    in_data = d; in_valid = 1'b1;
    while (in_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_mem[wptr] = expc(cur_f, cur_m, d);
    wptr++;
  endtask

  task automatic rd_chk(input int a, input string req);
    rd_addr = a[7:0];
    @(negedge clk);
    chk({rd_tr, rd_red, rd_grn, rd_blu} === exp_mem[a], req,
        {7'h0, rd_tr, rd_red, rd_grn, rd_blu}, {7'h0, exp_mem[a]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b0, "R1 ready", 32'(in_ready), 0);
    chk(done === 1'b0, "R1 done", 32'(done), 0);
    chk(reconv === 1'b1, "R1 reconv", 32'(reconv), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b0 && reconv === 1'b1, "R1 after release",
        {in_ready, reconv}, 32'h1);

    // every format with and without the monochrome override, 2 bpp
    for (int f = 0; f < 4; f++) begin
      for (int m = 0; m < 2; m++) begin
        begin_load(f, m[0], 0);
        chk(in_ready === 1'b1, "R2 ready after start", 32'(in_ready), 1);
        for (int i = 0; i < 4; i++) begin
          if (i == 3) chk(done === 1'b0, "R4 no early done", 32'(done), 0);
          push(pat(i, f * 2 + m));
        end
        chk(done === 1'b1 && in_ready === 1'b0, "R4 done after 4",
            {done, in_ready}, 32'h2);
        @(negedge clk);
        chk(done === 1'b0, "R4 done pulse", 32'(done), 0);
        for (int a = 0; a < 4; a++) rd_chk(a, ftag(f, m[0]));
        chk(reconv === 1'b0, "R11 same fmt", 32'(reconv), 0);
        fmt_sel = 2'(f ^ 1);
        #1;
        chk(reconv === 1'b1, "R11 other fmt", 32'(reconv), 1);
      end
    end

    // 4 bpp, format 2, gaps and a stray start mid-load
    begin_load(2, 1'b0, 1);
    for (int i = 0; i < 16; i++) begin
      if (i % 3 == 1) @(negedge clk);
      if (i == 5) begin
        fmt_sel = 2'd3; depth_sel = 2'd2; mono = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; fmt_sel = 2'd2; mono = 1'b0; depth_sel = 2'd1;
        chk(in_ready === 1'b1, "R2 stray start ignored", 32'(in_ready), 1);
      end
      if (i == 15) chk(done === 1'b0, "R4 no early done 16", 32'(done), 0);
      push(pat(i, 11));
    end
    chk(done === 1'b1 && in_ready === 1'b0, "R4 done after 16", {done, in_ready}, 32'h2);
    for (int a = 0; a < 16; a++) rd_chk(a, "R3 R8 gapped load");
    chk(reconv === 1'b0, "R11 after gapped load", 32'(reconv), 0);

    // 8 bpp, format 3, full depth
    begin_load(3, 1'b0, 2);
    for (int i = 0; i < 256; i++) begin
      if (i == 255) chk(done === 1'b0, "R4 no early done 256", 32'(done), 0);
      push(pat(i, 23));
    end
    chk(done === 1'b1 && in_ready === 1'b0, "R4 done after 256", {done, in_ready}, 32'h2);
    for (int a = 0; a < 256; a++) rd_chk(a, "R9 R12 full load");

    // words offered while idle are ignored
    in_data = 32'hFFFF_FFFF; in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R3 idle ready low", 32'(in_ready), 0);
    end
    in_valid = 1'b0;
    for (int a = 0; a < 4; a++) rd_chk(a, "R3 idle no write");

    // depth code 3: no palette
    begin_load(0, 1'b0, 3);
    chk(done === 1'b1 && in_ready === 1'b0, "R5 immediate done", {done, in_ready}, 32'h2);
    @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b0, "R5 stays idle", {done, in_ready}, 0);
    for (int a = 0; a < 4; a++) rd_chk(a, "R5 no write");
    fmt_sel = 2'd0;
    #1;
    chk(reconv === 1'b1, "R11 depth3 keeps reference", 32'(reconv), 1);
    fmt_sel = 2'd3;
    #1;
    chk(reconv === 1'b0, "R11 reference fmt3", 32'(reconv), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule